// File: doc/BRIEF.md
# Mode-Partitioned Packed Integer Multiplier

This block multiplies two 64-bit packed operands on a single array of sixteen 16-bit multiplier cells. A mode input regroups the array: all sixteen cells form one 64-bit multiply, or two groups of four form two independent 32-bit multiplies, or four single cells form four independent 16-bit multiplies. Each lane's result is the low half of its full product, truncated to the lane width, and it sits in the same bit positions as that lane's operands.

Cell (i, j) multiplies halfword i of operand A by halfword j of operand B. In the packed modes, cells whose halfwords belong to different lanes are not needed. Their enable is held low and their output register is forced to zero, which saves power. A 16-bit enable vector travels down the pipeline with each operation, so the active-cell pattern can be read next to the result it produced. A signed/unsigned select makes the top halfword cell of each lane sign-aware. The pipeline has two register stages: cell products, then the adder tree. It accepts one operation per cycle.

Top module: `sw_mul_array`

## Requirements
- R1: When mode is 2'b00, the block forms four 16-bit lanes. Lane k occupies bits [16k+15:16k], and its result is the low 16 bits of A lane k times B lane k.
- R2: When mode is 2'b01, the block forms two 32-bit lanes. Lane k occupies bits [32k+31:32k], and its result is the low 32 bits of A lane k times B lane k.
- R3: When mode is 2'b10 or 2'b11, the result is the low 64 bits of A times B.
- R4: out_vld rises exactly two rising clock edges after an accepted in_vld. Operations presented on consecutive cycles come out on consecutive cycles.
- R5: Bit 4*i+j of sub_en reports cell (i, j), where i is the A halfword and j is the B halfword. The vector is aligned with prod and reads 16'h8421 in mode 2'b00, 16'hCC33 in mode 2'b01 and 16'hFFFF in the 64-bit modes.
- R6: Whenever out_vld is low after reset, prod and sub_en are both zero.
- R7: is_signed has no effect on prod, because each truncated lane result is the same for signed and unsigned operands.
- R8: A low rst_n sampled at a rising edge clears out_vld, prod and sub_en, even while an operation is in flight.
- R9: A packed lane result never carries into or borrows from a neighbouring lane, including when operands are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Operation present on the inputs |
| mode | input | 2 | 00 quad 16-bit, 01 dual 32-bit, 1x single 64-bit |
| is_signed | input | 1 | Treat lane operands as two's complement |
| op_a | input | 64 | Packed operand A |
| op_b | input | 64 | Packed operand B |
| out_vld | output | 1 | Result present on prod |
| prod | output | 64 | Packed truncated products |
| sub_en | output | 16 | Active cells for the operation on prod |

## Verification
The hardest case to reach from the ports is a lane boundary under full load. An all-ones or 0x8000 halfword in a packed mode produces partial products that would spill into the next lane if any off-lane cell or any carry leaked across. The vector table therefore sets large values in adjacent lanes with different modes on back-to-back cycles. That also shows whether the mode and enable registers stay paired with their own data in the pipeline. A reset pulse is driven while a valid operation sits between the two stages.

// File: rtl/sw_mul_pkg.sv
// Shared sizing and mode encoding for the partitioned multiplier.
// Assumes the operand is a whole number of cell-width halfwords.
package sw_mul_pkg;
    localparam int unsigned CELL_W = 16;               // width of one multiplier cell
    localparam int unsigned N_HW   = 4;                // halfwords per operand
    localparam int unsigned DATA_W = CELL_W * N_HW;    // packed operand width
    localparam int unsigned N_CELL = N_HW * N_HW;      // cells in the array
    localparam int unsigned PP_W   = 2 * CELL_W + 2;   // signed cell product width
    localparam int unsigned GRP    = N_HW / 2;         // halfwords per 32-bit lane

    typedef enum logic [1:0] {
        MODE_Q16  = 2'b00,
        MODE_D32  = 2'b01,
        MODE_S64  = 2'b10,
        MODE_S64B = 2'b11
    } mul_mode_t;
endpackage

// File: rtl/sw_mul_ctl.sv
// Mode decoder: works out which cells take part in the current operation
// and which halfwords are the sign-bearing top of their lane.
// Assumes one operation per cycle; the enables are zero when in_vld is low.
module sw_mul_ctl
    import sw_mul_pkg::*;
(
    input  logic              in_vld,
    input  logic [1:0]        mode,
    input  logic              is_signed,
    output logic [N_CELL-1:0] cell_en,
    output logic [N_HW-1:0]   sgn_a,
    output logic [N_HW-1:0]   sgn_b
);
    // Cell (i,j) is used when halfwords i and j fall in the same lane.
    always_comb begin
        for (int i = 0; i < N_HW; i++) begin
            for (int j = 0; j < N_HW; j++) begin
                unique case (mode)
                    MODE_Q16: cell_en[i*N_HW+j] = in_vld && (i == j);
                    MODE_D32: cell_en[i*N_HW+j] = in_vld && ((i / GRP) == (j / GRP));
                    default:  cell_en[i*N_HW+j] = in_vld;
                endcase
            end
        end
    end

    // A halfword is sign-aware only when it is the top halfword of its lane.
    always_comb begin
        for (int i = 0; i < N_HW; i++) begin
            unique case (mode)
                MODE_Q16: sgn_a[i] = is_signed;
                MODE_D32: sgn_a[i] = is_signed && ((i % GRP) == GRP - 1);
                default:  sgn_a[i] = is_signed && (i == N_HW - 1);
            endcase
            sgn_b[i] = sgn_a[i];
        end
    end
endmodule

// File: rtl/sw_mul_cell.sv
// One 16x16 multiplier cell with its stage-1 output register.
// Each operand is extended by one bit (sign or zero) so that the cell works
// for both the top and the lower halfwords of a lane. When en is low the
// register is loaded with zero, so no switching passes on to the adder tree.
module sw_mul_cell
    import sw_mul_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [CELL_W-1:0]      a,
    input  logic [CELL_W-1:0]      b,
    input  logic                   a_sgn,
    input  logic                   b_sgn,
    output logic signed [PP_W-1:0] p_q
);
    logic signed [CELL_W:0]   a_x;
    logic signed [CELL_W:0]   b_x;
    logic signed [PP_W-1:0]   p_d;

    // Extend the operands and form the full signed product.
    always_comb begin
        a_x = {a_sgn & a[CELL_W-1], a};
        b_x = {b_sgn & b[CELL_W-1], b};
        p_d = PP_W'(a_x * b_x);
    end

    // Stage-1 register; it holds zero while the cell is gated.
    always_ff @(posedge clk) begin
        if (!rst_n)  p_q <= '0;
        else if (en) p_q <= p_d;
        else         p_q <= '0;
    end

    // R5
    gate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (p_q == '0));
endmodule

// File: rtl/sw_mul_sum.sv
// Adder tree: shifts each cell product to its position and adds the products
// of each lane, then picks the packing that the mode asks for.
// Assumes gated cells present zero; each lane sum is truncated to lane width.
module sw_mul_sum
    import sw_mul_pkg::*;
(
    input  logic [1:0]             mode,
    input  logic signed [PP_W-1:0] pp [N_CELL],
    output logic [DATA_W-1:0]      sum
);
    localparam int unsigned LANE32 = GRP * CELL_W;

    logic [DATA_W-1:0] r16;
    logic [DATA_W-1:0] r32;
    logic [DATA_W-1:0] r64;

    // Quad mode: each diagonal cell alone forms its lane.
    always_comb begin
        for (int k = 0; k < N_HW; k++)
            r16[k*CELL_W +: CELL_W] = pp[k*N_HW+k][CELL_W-1:0];
    end

    // Dual mode: sum the cells inside each 32-bit lane, weighted by position.
    always_comb begin
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] ext;
        for (int l = 0; l < N_HW / GRP; l++) begin
            acc = '0;
            for (int i = 0; i < GRP; i++) begin
                for (int j = 0; j < GRP; j++) begin
                    ext = DATA_W'(pp[(l*GRP+i)*N_HW + l*GRP+j]);
                    acc = acc + (ext << (CELL_W * (i + j)));
                end
            end
            r32[l*LANE32 +: LANE32] = acc[LANE32-1:0];
        end
    end

    // Single mode: sum every cell weighted by halfword position.
    always_comb begin
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] ext;
        acc = '0;
        for (int i = 0; i < N_HW; i++) begin
            for (int j = 0; j < N_HW; j++) begin
                ext = DATA_W'(pp[i*N_HW+j]);
                acc = acc + (ext << (CELL_W * (i + j)));
            end
        end
        r64 = acc;
    end

    // Pick the packing for the mode that travels with the data.
    always_comb begin
        unique case (mode)
            MODE_Q16: sum = r16;
            MODE_D32: sum = r32;
            default:  sum = r64;
        endcase
    end
endmodule

// File: rtl/sw_mul_array.sv
// Top: a 4x4 array of 16-bit cells regrouped by mode into 64-, 32- or 16-bit
// lanes. Stage 1 registers the cell products, stage 2 registers the lane sums.
// Latency is fixed at two cycles and the pipeline takes one operation per cycle.
// Assumes mode and is_signed are valid whenever in_vld is high.
module sw_mul_array
    import sw_mul_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [1:0]        mode,
    input  logic              is_signed,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              out_vld,
    output logic [DATA_W-1:0] prod,
    output logic [N_CELL-1:0] sub_en
);
    logic [N_CELL-1:0]      cell_en;
    logic [N_HW-1:0]        sgn_a;
    logic [N_HW-1:0]        sgn_b;
    logic signed [PP_W-1:0] pp [N_CELL];
    logic [DATA_W-1:0]      sum_d;

    logic                   vld_s1;
    logic [1:0]             mode_s1;
    logic [N_CELL-1:0]      en_s1;
    logic                   vld_s2;
    logic [DATA_W-1:0]      prod_s2;
    logic [N_CELL-1:0]      en_s2;

    sw_mul_ctl u_ctl (
        .in_vld    (in_vld),
        .mode      (mode),
        .is_signed (is_signed),
        .cell_en   (cell_en),
        .sgn_a     (sgn_a),
        .sgn_b     (sgn_b)
    );

    for (genvar i = 0; i < N_HW; i++) begin : g_row
        for (genvar j = 0; j < N_HW; j++) begin : g_col
            sw_mul_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (cell_en[i*N_HW+j]),
                .a     (op_a[i*CELL_W +: CELL_W]),
                .b     (op_b[j*CELL_W +: CELL_W]),
                .a_sgn (sgn_a[i]),
                .b_sgn (sgn_b[j]),
                .p_q   (pp[i*N_HW+j])
            );
        end
    end

    sw_mul_sum u_sum (
        .mode (mode_s1),
        .pp   (pp),
        .sum  (sum_d)
    );

    // Stage 1 side-band: valid, mode and enables travel with the cell products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_s1  <= 1'b0;
            mode_s1 <= MODE_Q16;
            en_s1   <= '0;
        end else begin
            vld_s1  <= in_vld;
            mode_s1 <= mode;
            en_s1   <= cell_en;
        end
    end

    // Stage 2: register the packed lane sums with their valid and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_s2  <= 1'b0;
            prod_s2 <= '0;
            en_s2   <= '0;
        end else begin
            vld_s2  <= vld_s1;
            prod_s2 <= sum_d;
            en_s2   <= en_s1;
        end
    end

    assign out_vld = vld_s2;
    assign prod    = prod_s2;
    assign sub_en  = en_s2;

    // R4
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> ##2 out_vld);

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (prod == '0 && sub_en == '0));

    // R5
    en_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ($countones(sub_en) == N_HW || $countones(sub_en) == 2 * N_HW
                     || $countones(sub_en) == N_CELL));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && prod == '0 && sub_en == '0));
endmodule

// File: tb/sim_sw_mul_array.sv
module sim_sw_mul_array;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        is_signed = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        out_vld;
    logic [63:0] prod;
    logic [15:0] sub_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sw_mul_array u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .mode(mode),
        .is_signed(is_signed), .op_a(op_a), .op_b(op_b),
        .out_vld(out_vld), .prod(prod), .sub_en(sub_en)
    );

    localparam int NV = 10;
    localparam logic [63:0] VA [NV] = '{
        64'h0001_0002_0003_0004, 64'hFFFF_FFFF_8000_1234, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h0000_FFFF_1234_5678, 64'h8000_0000_FFFF_FFFF, 64'h0000_0000_DEAD_BEEF,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 64'h8000_0000_0000_0001,
        64'hFFFF_FFFF_FFFF_FFFF};
    localparam logic [63:0] VB [NV] = '{
        64'h0005_0006_0007_0008, 64'hFFFF_0002_8000_5678, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h0000_0003_9ABC_DEF0, 64'h0000_0002_FFFF_FFFF, 64'h0000_0000_0000_1000,
        64'hFFFF_FFFF_FFFF_FFFF, 64'hFEDC_BA98_7654_3210, 64'h0000_0000_0000_0003,
        64'h0000_0000_0000_0002};
    localparam logic [1:0] VM [NV] = '{2'b00, 2'b00, 2'b00, 2'b01, 2'b01,
                                       2'b10, 2'b10, 2'b11, 2'b10, 2'b01};
    localparam logic VS [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1,
                                 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

    // Truncated lane products per R1..R3.
    function automatic logic [63:0] exp_prod(logic [63:0] a, logic [63:0] b, logic [1:0] m);
        logic [63:0] r;
        logic [15:0] t16;
        logic [31:0] t32;
        r = '0;
        if (m == 2'b00) begin
            for (int k = 0; k < 4; k++) begin
                t16 = a[16*k +: 16] * b[16*k +: 16];
                r[16*k +: 16] = t16;
            end
        end else if (m == 2'b01) begin
            for (int k = 0; k < 2; k++) begin
                t32 = a[32*k +: 32] * b[32*k +: 32];
                r[32*k +: 32] = t32;
            end
        end else begin
            r = a * b;
        end
        return r;
    endfunction

    // Enable pattern per R5.
    function automatic logic [15:0] exp_en(logic [1:0] m);
        if (m == 2'b00) return 16'h8421;
        if (m == 2'b01) return 16'hCC33;
        return 16'hFFFF;
    endfunction

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        chk("R8 reset vld", 64'(out_vld), 64'd0);
        chk("R8 reset prod", prod, 64'd0);
        chk("R8 reset en", 64'(sub_en), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk, back to back: results of vector k-2 checked while driving k (R1-R3, R4, R5, R7, R9)
        for (int k = 0; k < NV + 2; k++) begin
            if (k >= 2) begin
                chk("R4 out_vld", 64'(out_vld), 64'd1);
                chk(VM[k-2] == 2'b00 ? "R1/R9 quad prod" :
                    VM[k-2] == 2'b01 ? "R2/R9 dual prod" : "R3 single prod",
                    prod, exp_prod(VA[k-2], VB[k-2], VM[k-2]));
                chk("R5 sub_en", 64'(sub_en), 64'(exp_en(VM[k-2])));
            end
            if (k < NV) begin
                in_vld = 1'b1; op_a = VA[k]; op_b = VB[k];
                mode = VM[k]; is_signed = VS[k];
            end else begin
                in_vld = 1'b0; op_a = '0; op_b = '0;
            end
            @(negedge clk);
        end

        // R6: idle pipeline gives zeros
        chk("R6 idle vld", 64'(out_vld), 64'd0);
        chk("R6 idle prod", prod, 64'd0);
        chk("R6 idle en", 64'(sub_en), 64'd0);

        // R7: same operands signed and unsigned, quad mode with negative lanes
        in_vld = 1'b1; mode = 2'b00; is_signed = 1'b1;
        op_a = 64'h8001_FFFE_7FFF_C000; op_b = 64'hFFFF_8000_8001_0003;
        @(negedge clk);
        is_signed = 1'b0;
        @(negedge clk);
        in_vld = 1'b0;
        chk("R7 signed quad", prod, exp_prod(64'h8001_FFFE_7FFF_C000, 64'hFFFF_8000_8001_0003, 2'b00));
        @(negedge clk);
        chk("R7 unsigned quad", prod, exp_prod(64'h8001_FFFE_7FFF_C000, 64'hFFFF_8000_8001_0003, 2'b00));
        @(negedge clk);

        // R8: reset while an operation is between stages
        in_vld = 1'b1; mode = 2'b10; op_a = 64'h1234; op_b = 64'h5678;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 midflight vld", 64'(out_vld), 64'd0);
        chk("R8 midflight prod", prod, 64'd0);
        chk("R8 midflight en", 64'(sub_en), 64'd0);
        in_vld = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 flushed vld", 64'(out_vld), 64'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule